// File: doc/BRIEF.md
# Ring-Oscillator Entropy Sampler with Word FIFO

This block gathers random bits from a bank of 128 ring-oscillator outputs, arranged as 16 groups of eight. It turns them into 64-bit words and queues those words in a 64-entry FIFO. A host drains the FIFO through a single-cycle load strobe. The generator keeps topping the FIFO up whenever there is room, so every word the host takes out is replaced without any further request.

A control register written through `ctl_we`/`ctl_wdata` selects one of three production modes. Raw mode samples one chosen group of eight oscillators in parallel over eight cycles. Conditioned mode stirs a folded copy of the whole bank into a 64-bit shift-register mixer for 81 cycles per word. Deterministic mode runs the same mixer on zero input from a fixed seed, so its output is reproducible after every reset. A reset bit in the same register stops the generator and empties the FIFO. The FIFO fill level and a sticky underflow flag are visible as status outputs.

Top module: `rng_sampler`

## Requirements
- R1: Control word bits are: bit 0 enable, bit 1 entropy enable, bit 2 expose-raw, bits 6:3 group select, bit 7 reset. Mode decode is as follows. Enable clear means no production, whatever the other bits hold. Enable alone, or enable with expose-raw but no entropy enable, gives deterministic mode. Enable with entropy enable gives conditioned mode. Adding expose-raw to those two gives raw mode.
- R2: In raw mode, the word holds eight samples, numbered k = 0..7. On sample k, oscillator j (0..7) of selected group g, which is input bit g*8+j, is stored at word bit k*8+j.
- R3: A raw word is pushed on the 8th clock edge after the control write edge. After 7 edges the FIFO level is still unchanged.
- R4: A deterministic or conditioned word is pushed on the 81st edge after the control write edge. The word is the mixer state after its 81st step. One step works on a 64-bit state: shift it left by one, XOR in 0x1B if the old bit 63 was set, then XOR in the input. The seed is 0xD3C15A7E9B246F81. In deterministic mode the input is zero.
- R5: After entropy is turned on, whether from a state with it off or after a reset, the first sample of the bank reads as all zeros. Later samples take the input bits.
- R6: The FIFO holds 64 words. Production stops while it is full. After a read from a full FIFO, the missing word is pushed 8 edges later in raw mode.
- R7: A load strobe returns the oldest word on `rd_data` one edge later and lowers the level by one.
- R8: A load from an empty FIFO returns zero and sets `underflow`. The flag stays set across any control write that lacks the reset bit.
- R9: A control write with the reset bit empties the FIFO, clears `underflow`, clears every mode bit and returns the mixer to its seed. Out of reset, the level is 0, `underflow` is 0 and `rd_data` is 0.
- R10: Any control write discards a partly built word and starts a fresh one. Words already in the FIFO are kept, so a new group takes effect from the next whole word.
- R11: In conditioned mode, each mixer step takes as input the XOR of input bits 63:0 and 127:64. The zeroing of R5 still applies.
- R12: When enable is cleared, no word is pushed and the level holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control word (see R1) |
| osc_in | input | 128 | Ring-oscillator sample bank |
| rd_en | input | 1 | Load strobe, removes one word |
| rd_data | output | 64 | Word returned by the last load |
| fifo_level | output | 7 | Number of words held |
| underflow | output | 1 | Sticky empty-read flag |

## Verification
The bench rebuilds raw words from random per-cycle oscillator patterns and random groups. A wrong bit order or a wrong group slice shows up as a mismatched word, and if the first sample is not zeroed, byte 0 comes out nonzero. Level probes one edge before and on the expected push edge catch latencies that are off by one. They also catch a partial word that survives an abort, because it lands four edges too early. A second read after draining checks oldest-first order. The bench also compares deterministic and conditioned words against its own mixer model, which exposes a missing reseed or a mis-folded input. It reads from an empty FIFO to check the zero result and the sticky flag, and checks that the flag is cleared only by the reset bit.

// File: rtl/rng_pkg.sv
package rng_pkg;
  typedef enum logic [1:0] {MODE_OFF, MODE_DET, MODE_COND, MODE_RAW} mode_e;

  localparam int BIT_EN    = 0;
  localparam int BIT_ENT   = 1;
  localparam int BIT_EXP   = 2;
  localparam int GSEL_LSB  = 3;

  function automatic mode_e decode_mode(input logic en, input logic ent, input logic expo);
    if (!en)       return MODE_OFF;
    else if (!ent) return MODE_DET;
    else if (!expo) return MODE_COND;
    else           return MODE_RAW;
  endfunction
endpackage

// File: rtl/rng_ctl.sv
module rng_ctl
  import rng_pkg::*;
#(
  parameter int GSEL_W = 4,
  localparam int CTL_W = GSEL_LSB + GSEL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output mode_e             mode,
  output logic [GSEL_W-1:0] grp,
  output logic              wr_pulse,
  output logic              rst_pulse
);
  logic en_q, ent_q, exp_q;
  logic [GSEL_W-1:0] grp_q;

  assign wr_pulse  = ctl_we;
  assign rst_pulse = ctl_we & ctl_wdata[CTL_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; ent_q <= 1'b0; exp_q <= 1'b0; grp_q <= '0;
    end else if (ctl_we) begin
      if (ctl_wdata[CTL_W-1]) begin
        en_q <= 1'b0; ent_q <= 1'b0; exp_q <= 1'b0; grp_q <= '0;
      end else begin
        en_q  <= ctl_wdata[BIT_EN];
        ent_q <= ctl_wdata[BIT_ENT];
        exp_q <= ctl_wdata[BIT_EXP];
        grp_q <= ctl_wdata[GSEL_LSB +: GSEL_W];
      end
    end
  end

  assign mode = decode_mode(en_q, ent_q, exp_q);
  assign grp  = grp_q;
endmodule

// File: rtl/rng_producer.sv
module rng_producer
  import rng_pkg::*;
#(
  parameter int N_OSC   = 128,
  parameter int GRP_W   = 8,
  parameter int WORD_W  = 64,
  parameter int MIX_CYC = 81,
  parameter logic [WORD_W-1:0] SEED = 64'hD3C1_5A7E_9B24_6F81,
  parameter logic [WORD_W-1:0] TAPS = 64'h1B,
  localparam int GSEL_W  = $clog2(N_OSC / GRP_W),
  localparam int RAW_CYC = WORD_W / GRP_W,
  localparam int CNT_W   = $clog2(MIX_CYC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_e             mode,
  input  logic [GSEL_W-1:0] grp,
  input  logic              abort,
  input  logic              reseed,
  input  logic              full,
  input  logic [N_OSC-1:0]  osc,
  output logic              push,
  output logic [WORD_W-1:0] push_data
);
  function automatic logic [WORD_W-1:0] mix_step(input logic [WORD_W-1:0] s,
                                                 input logic [WORD_W-1:0] din);
    return {s[WORD_W-2:0], 1'b0} ^ (s[WORD_W-1] ? TAPS : '0) ^ din;
  endfunction

  function automatic logic [WORD_W-1:0] pack_slot(input logic [WORD_W-1:0] w,
                                                  input logic [CNT_W-1:0]  slot,
                                                  input logic [GRP_W-1:0]  bits);
    logic [WORD_W-1:0] ext;
    ext = WORD_W'(bits);
    return w | (ext << (int'(slot) * GRP_W));
  endfunction

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] word_q, lfsr_q, fold, mix_in, lfsr_nxt, word_nxt;
  logic [N_OSC-1:0]  sample;
  logic [GRP_W-1:0]  grp_bits;
  logic              warm_q, ent_mode, step, last;

  always_comb begin
    ent_mode = (mode == MODE_COND) || (mode == MODE_RAW);
    step     = (mode != MODE_OFF) && !full && !abort;
    sample   = warm_q ? osc : '0;
    grp_bits = sample[grp*GRP_W +: GRP_W];
    fold     = '0;
    for (int i = 0; i < N_OSC; i++) fold[i % WORD_W] ^= sample[i];
    mix_in   = (mode == MODE_DET) ? '0 : fold;
    lfsr_nxt = mix_step(lfsr_q, mix_in);
    word_nxt = pack_slot(word_q, cnt_q, grp_bits);
    last     = (mode == MODE_RAW) ? (cnt_q == CNT_W'(RAW_CYC - 1))
                                  : (cnt_q == CNT_W'(MIX_CYC - 1));
    push      = step && last;
    push_data = (mode == MODE_RAW) ? word_nxt : lfsr_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; word_q <= '0; lfsr_q <= SEED; warm_q <= 1'b0;
    end else begin
      if (abort) begin
        cnt_q  <= '0;
        word_q <= '0;
      end else if (step) begin
        cnt_q  <= last ? '0 : cnt_q + 1'b1;
        word_q <= (last || mode != MODE_RAW) ? '0 : word_nxt;
      end
      if (reseed)                         lfsr_q <= SEED;
      else if (step && mode != MODE_RAW)  lfsr_q <= lfsr_nxt;
      if (reseed || !ent_mode)            warm_q <= 1'b0;
      else if (step)                      warm_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rng_fifo.sv
module rng_fifo #(
  parameter int WORD_W = 64,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              underflow
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp_q, rp_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              pop;

  assign pop   = rd_en && (lvl_q != '0);
  assign full  = (lvl_q == LVL_W'(DEPTH));
  assign level = lvl_q;

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; lvl_q <= '0; rd_data <= '0; underflow <= 1'b0;
    end else begin
      if (rd_en) rd_data <= pop ? mem[rp_q] : '0;
      if (flush) begin
        wp_q <= '0; rp_q <= '0; lvl_q <= '0; underflow <= 1'b0;
      end else begin
        if (push) wp_q <= wp_q + 1'b1;
        if (pop)  rp_q <= rp_q + 1'b1;
        lvl_q <= lvl_q + LVL_W'(push) - LVL_W'(pop);
        if (rd_en && !pop) underflow <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rng_sampler.sv
module rng_sampler
  import rng_pkg::*;
#(
  parameter int N_OSC   = 128,
  parameter int GRP_W   = 8,
  parameter int WORD_W  = 64,
  parameter int DEPTH   = 64,
  parameter int MIX_CYC = 81,
  localparam int GSEL_W = $clog2(N_OSC / GRP_W),
  localparam int CTL_W  = GSEL_LSB + GSEL_W + 1,
  localparam int LVL_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic [N_OSC-1:0]  osc_in,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic [LVL_W-1:0]  fifo_level,
  output logic              underflow
);
  mode_e             mode;
  logic [GSEL_W-1:0] grp;
  logic              wr_pulse, rst_pulse, gen_push, fifo_full, gen_off;
  logic [WORD_W-1:0] gen_word;

  assign gen_off = (mode == MODE_OFF);

  rng_ctl #(.GSEL_W(GSEL_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .mode(mode), .grp(grp), .wr_pulse(wr_pulse), .rst_pulse(rst_pulse)
  );

  rng_producer #(.N_OSC(N_OSC), .GRP_W(GRP_W), .WORD_W(WORD_W), .MIX_CYC(MIX_CYC)) u_gen (
    .clk(clk), .rst_n(rst_n), .mode(mode), .grp(grp), .abort(wr_pulse),
    .reseed(rst_pulse), .full(fifo_full), .osc(osc_in),
    .push(gen_push), .push_data(gen_word)
  );

  rng_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(rst_pulse), .push(gen_push),
    .push_data(gen_word), .rd_en(rd_en), .rd_data(rd_data),
    .level(fifo_level), .full(fifo_full), .underflow(underflow)
  );
endmodule

// File: rtl/rng_sampler_chk.sv
module rng_sampler_chk #(
  parameter int WORD_W = 64,
  parameter int DEPTH  = 64,
  parameter int LVL_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_we,
  input logic              ctl_rst,
  input logic              gen_off,
  input logic              push,
  input logic              rd_en,
  input logic [LVL_W-1:0]  level,
  input logic              underflow,
  input logic [WORD_W-1:0] rd_data
);
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH)); // R6
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (level < LVL_W'(DEPTH))); // R6
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && level == '0 && !ctl_rst) |=> (rd_data == '0 && underflow)); // R8
  AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !ctl_rst) |=> underflow); // R8
  AST_RESET_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rst |=> (level == '0 && !underflow)); // R9
  AST_WRITE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |-> !push); // R10
  AST_OFF_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    gen_off |-> !push); // R12
endmodule

bind rng_sampler rng_sampler_chk #(.WORD_W(WORD_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_rst(rst_pulse), .gen_off(gen_off),
  .push(gen_push), .rd_en(rd_en), .level(fifo_level), .underflow(underflow),
  .rd_data(rd_data)
);

// File: tb/rng_sampler_tb.sv
module rng_sampler_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ctl_we = 1'b0;
  logic [7:0]   ctl_wdata = '0;
  logic [127:0] osc_in = '0;
  logic         rd_en = 1'b0;
  logic [63:0]  rd_data;
  logic [6:0]   fifo_level;
  logic         underflow;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  localparam logic [63:0] B_SEED = 64'hD3C15A7E9B246F81;

  always #5 clk = ~clk;

  rng_sampler u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .osc_in(osc_in), .rd_en(rd_en), .rd_data(rd_data),
    .fifo_level(fifo_level), .underflow(underflow)
  );

  function automatic logic [63:0] b_step(logic [63:0] s, logic [63:0] din);
    logic top;
    top = s[63];
    s = s << 1;
    if (top) s[7:0] = s[7:0] ^ 8'h1B;
    return s ^ din;
  endfunction

  function automatic logic [63:0] b_fold(logic [127:0] v);
    return v[127:64] ^ v[63:0];
  endfunction

  function automatic logic [63:0] b_det(int nwords);
    logic [63:0] s = B_SEED;
    for (int i = 0; i < nwords * 81; i++) s = b_step(s, 64'd0);
    return s;
  endfunction

  function automatic logic [7:0] b_ctl(bit en, bit ent, bit ex, int g, bit rst);
    return {rst, 4'(g), ex, ent, en};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic rd(output logic [63:0] d);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0]  d, e;
    logic [127:0] vals [16];
    logic [127:0] c;
    void'($urandom(32'h5A17_C0DE));
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R9 reset level", 64'(fifo_level), 0);
    check("R9 reset underflow", 64'(underflow), 0);
    check("R9 reset rd_data", rd_data, 0);

    // R2 R3 R5: random groups, per-cycle random oscillator patterns
    for (int it = 0; it < 3; it++) begin
      int g = int'($urandom_range(15, 0));
      wr(b_ctl(0, 0, 0, 0, 1));
      wr(b_ctl(1, 1, 1, g, 0));
      for (int k = 0; k < 16; k++) begin
        vals[k] = {$urandom, $urandom, $urandom, $urandom};
        osc_in = vals[k];
        if (k == 7) check("R3 level before 8th edge", 64'(fifo_level), 0);
        @(negedge clk);
      end
      check("R3 level after two words", 64'(fifo_level), 2);
      for (int w = 0; w < 2; w++) begin
        e = '0;
        for (int k = 0; k < 8; k++)
          for (int j = 0; j < 8; j++)
            e[k*8+j] = (w == 0 && k == 0) ? 1'b0 : vals[w*8+k][g*8+j];
        rd(d);
        check(w == 0 ? "R5 R2 first raw word" : "R2 R7 second raw word", d, e);
      end
    end

    // R4 R9: deterministic constant, twice to confirm reseed
    for (int it = 0; it < 2; it++) begin
      wr(b_ctl(0, 0, 0, 0, 1));
      wr(b_ctl(1, 0, 0, 0, 0));
      idle(80);
      check("R4 det level at 80", 64'(fifo_level), 0);
      idle(1);
      check("R4 det level at 81", 64'(fifo_level), 1);
      rd(d);
      check("R4 R9 det first word", d, b_det(1));
    end
    while (fifo_level == 0) idle(1);
    rd(d);
    check("R4 det second word", d, b_det(2));

    // R11: conditioned mode
    c = {$urandom, $urandom, $urandom, $urandom};
    osc_in = c;
    wr(b_ctl(0, 0, 0, 0, 1));
    wr(b_ctl(1, 1, 0, 0, 0));
    idle(81);
    check("R11 cond level", 64'(fifo_level), 1);
    rd(d);
    e = b_step(B_SEED, 64'd0);
    for (int i = 1; i < 81; i++) e = b_step(e, b_fold(c));
    check("R11 cond word", d, e);

    // R1: decode corners
    wr(b_ctl(0, 0, 0, 0, 1));
    wr(b_ctl(0, 1, 1, 5, 0));
    idle(100);
    check("R1 enable clear no words", 64'(fifo_level), 0);
    wr(b_ctl(0, 0, 0, 0, 1));
    wr(b_ctl(1, 0, 1, 5, 0));
    idle(81);
    rd(d);
    check("R1 enable+expose is deterministic", d, b_det(1));

    // R6 R7: fill, drain one, refill
    begin
      int g = int'($urandom_range(15, 0));
      c = {$urandom, $urandom, $urandom, $urandom};
      osc_in = c;
      wr(b_ctl(0, 0, 0, 0, 1));
      wr(b_ctl(1, 1, 1, g, 0));
      idle(520);
      check("R6 full level", 64'(fifo_level), 64);
      rd(d);
      e = {8{c[g*8 +: 8]}};
      e[7:0] = 8'h00;
      check("R7 oldest word", d, e);
      idle(7);
      check("R6 level before refill", 64'(fifo_level), 63);
      idle(1);
      check("R6 refilled", 64'(fifo_level), 64);
      rd(d);
      check("R7 next word", d, {8{c[g*8 +: 8]}});
    end

    // R8 R9: flush then empty read
    wr(b_ctl(0, 0, 0, 0, 1));
    check("R9 flush level", 64'(fifo_level), 0);
    rd(d);
    check("R8 empty read data", d, 0);
    check("R8 underflow set", 64'(underflow), 1);
    wr(b_ctl(0, 1, 0, 3, 0));
    check("R8 underflow sticky", 64'(underflow), 1);
    wr(b_ctl(0, 0, 0, 0, 1));
    check("R9 underflow cleared", 64'(underflow), 0);

    // R10 R12: abort mid word, group change, disable
    c = {$urandom, $urandom, $urandom, $urandom};
    osc_in = c;
    wr(b_ctl(1, 1, 1, 2, 0));
    idle(8);
    check("R10 first word in", 64'(fifo_level), 1);
    idle(4);
    wr(b_ctl(1, 1, 1, 9, 0));
    check("R10 words kept", 64'(fifo_level), 1);
    idle(7);
    check("R10 partial discarded", 64'(fifo_level), 1);
    idle(1);
    check("R10 fresh word", 64'(fifo_level), 2);
    wr(b_ctl(0, 1, 1, 9, 0));
    idle(100);
    check("R12 disabled level holds", 64'(fifo_level), 2);
    rd(d);
    e = {8{c[2*8 +: 8]}};
    e[7:0] = 8'h00;
    check("R10 old group word", d, e);
    rd(d);
    check("R10 new group word", d, {8{c[9*8 +: 8]}});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule